// File: doc/BRIEF.md
# Idle Wake-Up Sequencer

This block parks a processor core in a low-power idle state and brings it back when a wake event arrives. An idle request gates the core clock off and raises a busy flag. While the core sleeps, four wake sources are watched: the OR of the interrupt lines whose enable bits are set, a watchdog interrupt, a non-maskable interrupt and a reset request. Each source passes through its own detector. The detector either needs two consecutive high samples, or it runs a sampling glitch filter when that source's qualifier enable is set.

The first source that is recognised starts a resume countdown. The length of the countdown depends on where the core fetches code after it wakes. The count is short for on-chip SRAM or a flash that is already awake. It is much longer for a flash that must first leave its own sleep state. When the countdown ends, the block raises a one-cycle resume strobe and reopens the core clock in that same cycle. The strobe marks the point where the instruction after the idle instruction begins. Interrupt service latency is outside this block. Every source recognised between idle entry and resume is recorded in a status mask that the core can read afterwards.

All pins are plain control and status signals. No data stream passes through the block, so no pin carries a valid/ready handshake.

Top module: `idle_wake_seq`

## Requirements
- R1: After reset, core_clk_en is 1, busy is 0, resume is 0 and wake_seen is 0.
- R2: When idle_req is sampled high while the core runs, then in the next cycle core_clk_en is 0, busy is 1 and wake_seen is cleared to 0.
- R3: An unqualified source is recognised only when it is sampled high at two consecutive clock edges. A pulse seen at a single edge has no effect.
- R4: Bit i of irq wakes the core only while irq_en[i] is 1. The watchdog, non-maskable and reset-request lines need no enable.
- R5: With an unqualified source, resume is high in the cycle after the D-th clock edge that follows the first edge at which the source is sampled high. D is 8 when mem_sel is 0 (SRAM) or 1 (flash awake).
- R6: With qualification on and qual_prd = 0, the source is sampled at every edge and is recognised at its fifth consecutive high sample. Resume then comes D+3 edges after the first high sample.
- R7: With qualification on and qual_prd = Q > 0, the source is sampled once every 2Q cycles and needs five consecutive high samples. A pulse of at most 8Q cycles is never accepted. A pulse of at least 10Q+1 cycles always is.
- R8: When mem_sel is 2 (flash asleep) or 3, D is 1050 instead of 8.
- R9: The first recognised source starts the countdown. wake_seen records every source recognised from idle entry until resume: bit 0 is the enabled-interrupt OR, bit 1 the watchdog, bit 2 the non-maskable interrupt and bit 3 the reset request.
- R10: idle_req has no effect while busy. It neither clears wake_seen nor changes the resume timing.
- R11: resume is high for exactly one cycle. In that cycle core_clk_en is already 1 and busy is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_req | input | 1 | Request to enter idle |
| irq | input | N_IRQ | Maskable interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| wdog_wake | input | 1 | Watchdog interrupt |
| nmi_wake | input | 1 | Non-maskable interrupt |
| rstreq_wake | input | 1 | Reset request |
| qual_en | input | 4 | Per-source qualifier enable (bit order as in wake_seen) |
| qual_prd | input | QPRD_W | Qualifier period; sampling interval is 2*qual_prd cycles, or 1 cycle when 0 |
| mem_sel | input | 2 | Code memory: 0 SRAM, 1 flash awake, 2 flash asleep |
| core_clk_en | output | 1 | Core clock enable, 0 while idle |
| resume | output | 1 | One-cycle strobe when execution resumes |
| busy | output | 1 | High from idle entry until resume |
| wake_seen | output | 4 | Sources recognised during the last idle period |

## Verification
The qualifier with a period above zero is the hardest case to drive from the ports. Its sampling phase starts at idle entry, so the exact cycle of acceptance cannot be seen from outside. The stimulus therefore brackets the filter. A pulse of exactly 8Q cycles must be rejected wherever the samples fall. A pulse of 10Q+1 cycles must produce resume inside the latency window that every possible sampling phase allows. The staggered multi-source case raises a second source only after the countdown has started, which shows that late sources are still recorded without restarting the count.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;
  localparam int NSRC = 4;
  localparam int SRC_IRQ   = 0;
  localparam int SRC_WDOG  = 1;
  localparam int SRC_NMI   = 2;
  localparam int SRC_RSTRQ = 3;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_COUNT = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    MEM_SRAM      = 2'd0,
    MEM_FLASH_ON  = 2'd1,
    MEM_FLASH_OFF = 2'd2
  } code_mem_e;
endpackage

// File: rtl/wake_qual.sv
// Per-source wake detector: two-sample check, or a sampling glitch filter.
module wake_qual #(
  parameter int QPRD_W = 8,
  parameter int NHIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              line,
  input  logic              qual_on,
  input  logic [QPRD_W-1:0] prd,
  output logic              det
);
  localparam int TW = QPRD_W + 1;
  localparam int HW = $clog2(NHIT);
  localparam logic [HW-1:0] HIT_TOP = HW'(NHIT - 1);

  logic [TW-1:0] tick_cnt;
  logic [TW-1:0] tick_last;
  logic          tick;
  logic          prev;
  logic [HW-1:0] hits;

  // Sampling interval is 2*prd cycles; prd == 0 samples every cycle.
  always_comb begin
    if (prd == '0) tick_last = '0;
    else           tick_last = {prd, 1'b0} - TW'(1);
    tick = (tick_cnt == tick_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      prev     <= 1'b0;
      hits     <= '0;
    end else if (!arm) begin
      tick_cnt <= '0;
      prev     <= 1'b0;
      hits     <= '0;
    end else begin
      prev     <= line;
      tick_cnt <= tick ? '0 : tick_cnt + TW'(1);
      if (tick) begin
        if (!line)               hits <= '0;
        else if (hits != HIT_TOP) hits <= hits + HW'(1);
      end
    end
  end

  always_comb begin
    if (qual_on) det = arm & tick & line & (hits == HIT_TOP);
    else         det = arm & line & prev;
  end
endmodule

// File: rtl/resume_timer.sv
// Resume countdown; expire is high in the last counted cycle.
module resume_timer #(
  parameter int SHORT_DLY = 8,
  parameter int LONG_DLY  = 1050
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic expire
);
  localparam int CNT_W = $clog2(LONG_DLY + 1);
  localparam logic [CNT_W-1:0] LOAD_S = CNT_W'(SHORT_DLY - 2);
  localparam logic [CNT_W-1:0] LOAD_L = CNT_W'(LONG_DLY - 2);

  logic [CNT_W-1:0] cnt;
  logic             run;

  assign expire = run & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= long_sel ? LOAD_L : LOAD_S;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/idle_wake_seq.sv
module idle_wake_seq
  import idle_wake_pkg::*;
#(
  parameter int N_IRQ     = 4,
  parameter int QPRD_W    = 8,
  parameter int NHIT      = 5,
  parameter int SHORT_DLY = 8,
  parameter int LONG_DLY  = 1050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic [N_IRQ-1:0]  irq,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              wdog_wake,
  input  logic              nmi_wake,
  input  logic              rstreq_wake,
  input  logic [NSRC-1:0]   qual_en,
  input  logic [QPRD_W-1:0] qual_prd,
  input  logic [1:0]        mem_sel,
  output logic              core_clk_en,
  output logic              resume,
  output logic              busy,
  output logic [NSRC-1:0]   wake_seen
);
  seq_st_e         state;
  logic [NSRC-1:0] src_line;
  logic [NSRC-1:0] det;
  logic            arm;
  logic            load;
  logic            expire;

  always_comb begin
    src_line            = '0;
    src_line[SRC_IRQ]   = |(irq & irq_en);
    src_line[SRC_WDOG]  = wdog_wake;
    src_line[SRC_NMI]   = nmi_wake;
    src_line[SRC_RSTRQ] = rstreq_wake;
  end

  assign arm  = (state != ST_RUN);
  assign load = (state == ST_SLEEP) && (|det);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    wake_qual #(.QPRD_W(QPRD_W), .NHIT(NHIT)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .line    (src_line[g]),
      .qual_on (qual_en[g]),
      .prd     (qual_prd),
      .det     (det[g])
    );
  end

  resume_timer #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .long_sel (mem_sel[1]),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      resume    <= 1'b0;
      wake_seen <= '0;
    end else begin
      resume <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (idle_req) begin
            state     <= ST_SLEEP;
            wake_seen <= '0;
          end
        end
        ST_SLEEP: begin
          wake_seen <= wake_seen | det;
          if (|det) state <= ST_COUNT;
        end
        ST_COUNT: begin
          wake_seen <= wake_seen | det;
          if (expire) begin
            state  <= ST_RUN;
            resume <= 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign core_clk_en = (state == ST_RUN);
  assign busy        = (state != ST_RUN);
endmodule

// File: rtl/idle_wake_seq_chk.sv
module idle_wake_seq_chk
  import idle_wake_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            idle_req,
  input logic            core_clk_en,
  input logic            resume,
  input logic            busy,
  input logic [NSRC-1:0] wake_seen
);
  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  p_gate_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (core_clk_en && !busy && $past(busy)));

  p_gate_vs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en != busy);

  p_idle_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && idle_req) |=> (busy && wake_seen == '0));

  p_seen_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((wake_seen & $past(wake_seen)) == $past(wake_seen)));

  p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idle_req) |=> (busy || resume));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !resume);
endmodule

bind idle_wake_seq idle_wake_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idle_req    (idle_req),
  .core_clk_en (core_clk_en),
  .resume      (resume),
  .busy        (busy),
  .wake_seen   (wake_seen)
);

// File: tb/idle_wake_seq_tb.sv
`timescale 1ns/100ps
module idle_wake_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_req = 1'b0;
  logic [3:0] irq = '0;
  logic [3:0] irq_en = '0;
  logic       wdog_wake = 1'b0;
  logic       nmi_wake = 1'b0;
  logic       rstreq_wake = 1'b0;
  logic [3:0] qual_en = '0;
  logic [7:0] qual_prd = '0;
  logic [1:0] mem_sel = '0;
  logic       core_clk_en, resume, busy;
  logic [3:0] wake_seen;

  always #2.5 clk = ~clk;

  idle_wake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .irq(irq), .irq_en(irq_en),
    .wdog_wake(wdog_wake), .nmi_wake(nmi_wake), .rstreq_wake(rstreq_wake),
    .qual_en(qual_en), .qual_prd(qual_prd), .mem_sel(mem_sel),
    .core_clk_en(core_clk_en), .resume(resume), .busy(busy), .wake_seen(wake_seen)
  );

  typedef struct {
    int         lo;
    int         hi;
    logic [3:0] seen;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   t0 = 0;
  bit   finished = 0;
  logic prev_res = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops the expected item when the resume strobe appears.
  always @(negedge clk) begin
    if (rst_n) begin
      if (resume && prev_res) chk(0, "R11 strobe longer than one cycle", 1, 0);
      if (resume) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected resume", 1, 0);
        end else begin
          exp_t e;
          int lat;
          e   = exp_q.pop_front();
          lat = cyc - t0;
          chk(lat >= e.lo && lat <= e.hi, e.tag, lat, e.lo);
          chk(wake_seen == e.seen, "R9 wake_seen at resume", int'(wake_seen), int'(e.seen));
          chk(core_clk_en && !busy, "R11 gate open at resume", int'({core_clk_en, busy}), 2);
        end
      end
      prev_res <= resume;
    end
  end

  task automatic push(input int lo, input int hi, input logic [3:0] seen, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.seen = seen; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic enter_idle();
    @(negedge clk) idle_req = 1'b1;
    @(negedge clk) idle_req = 1'b0;
    chk(busy == 1'b1 && core_clk_en == 1'b0, "R2 idle entry gates clock", int'({busy, core_clk_en}), 2);
    chk(wake_seen == 4'b0, "R2 wake_seen cleared", int'(wake_seen), 0);
  endtask

  task automatic wait_resume();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R5 resume never arrived", exp_q.size(), 0);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    if (!finished) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(core_clk_en == 1'b1, "R1 core_clk_en after reset", core_clk_en, 1);
    chk(busy == 1'b0 && resume == 1'b0, "R1 busy/resume after reset", int'({busy, resume}), 0);
    chk(wake_seen == 4'b0, "R1 wake_seen after reset", int'(wake_seen), 0);

    // R3: single-edge pulse ignored, two-edge pulse accepted (R5 latency D+1)
    mem_sel = 2'd0;
    enter_idle();
    @(negedge clk) nmi_wake = 1'b1;
    @(negedge clk) nmi_wake = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R3 one-edge pulse ignored", busy, 1);
    push(9, 9, 4'b0100, "R3 R5 two-edge pulse latency");
    @(negedge clk); nmi_wake = 1'b1; t0 = cyc;
    repeat (2) @(negedge clk);
    nmi_wake = 1'b0;
    wait_resume();

    // R4: masked interrupt ignored, enabled one wakes (flash awake, R5)
    mem_sel = 2'd1;
    irq_en  = 4'b0100;
    enter_idle();
    @(negedge clk) irq = 4'b1011;
    repeat (10) @(negedge clk);
    irq = 4'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R4 masked interrupts ignored", busy, 1);
    push(9, 9, 4'b0001, "R4 R5 enabled interrupt latency");
    irq[2] = 1'b1; t0 = cyc;
    wait_resume();
    irq = 4'b0;

    // R6: qualified, every-cycle sampling
    qual_en  = 4'b1000;
    qual_prd = 8'd0;
    enter_idle();
    push(12, 12, 4'b1000, "R6 qualified period 0 latency");
    @(negedge clk); rstreq_wake = 1'b1; t0 = cyc;
    wait_resume();
    rstreq_wake = 1'b0;

    // R7: qualified, Q=3 (sample every 6 cycles)
    qual_en  = 4'b0010;
    qual_prd = 8'd3;
    enter_idle();
    @(negedge clk) wdog_wake = 1'b1;
    repeat (24) @(negedge clk);
    wdog_wake = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R7 pulse of 8Q cycles rejected", busy, 1);
    push(32, 37, 4'b0010, "R7 pulse of 10Q+1 cycles accepted");
    wdog_wake = 1'b1; t0 = cyc;
    repeat (31) @(negedge clk);
    wdog_wake = 1'b0;
    wait_resume();
    qual_en = 4'b0;

    // R8: flash asleep -> long delay
    mem_sel = 2'd2;
    enter_idle();
    push(1051, 1051, 4'b0100, "R8 sleeping flash latency");
    @(negedge clk); nmi_wake = 1'b1; t0 = cyc;
    wait_resume();
    nmi_wake = 1'b0;

    // R9: simultaneous and staggered sources
    mem_sel = 2'd0;
    enter_idle();
    push(9, 9, 4'b0110, "R9 simultaneous sources latency");
    @(negedge clk); wdog_wake = 1'b1; nmi_wake = 1'b1; t0 = cyc;
    wait_resume();
    wdog_wake = 1'b0; nmi_wake = 1'b0;
    enter_idle();
    push(9, 9, 4'b1001, "R9 staggered sources latency");
    @(negedge clk); rstreq_wake = 1'b1; t0 = cyc;
    repeat (3) @(negedge clk);
    irq[2] = 1'b1;
    wait_resume();
    rstreq_wake = 1'b0; irq = 4'b0;

    // R10: idle_req during countdown ignored
    enter_idle();
    push(9, 9, 4'b0100, "R10 idle_req during count keeps latency");
    @(negedge clk); nmi_wake = 1'b1; t0 = cyc;
    repeat (4) @(negedge clk);
    idle_req = 1'b1;
    @(negedge clk) idle_req = 1'b0;
    wait_resume();
    nmi_wake = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && core_clk_en == 1'b1, "R10 no idle re-entry", int'({busy, core_clk_en}), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule